// File: doc/BRIEF.md
# Timer Channel Interrupt Router

This block sits behind a bank of timer comparators and decides what each channel's match event turns into. A channel can deliver its interrupt in one of three ways. It can send a message write with a programmable address and data. It can send a one-cycle pulse request to an interrupt-controller pin. It can hold a level request on a pin. Every channel holds a 64-bit configuration word that mixes writable control fields with read-only capability fields. The block checks each write to that word. It also keeps one level-status bit per channel and releases the pin when software clears that bit.

The pin requests are one-cycle strobes on three 32-bit vectors: assert, deassert and pulse. Bit `k` of a vector addresses controller pin `k`. The interrupt controller that receives them has `PIN_COUNT` pins. That number fixes which pins a channel may legally select. Every request appears one clock after the edge that sampled the cause. Within one cycle the block applies its inputs to a channel in this order: the configuration write, then the message-register write, then the status clear, then the match.

Top module: `tir_router`

## Requirements
- R1: A match on a channel whose interrupt-enable bit (config bit 2) is clear produces no request of any kind.
- R2: A match on a channel whose level-status bit is already set produces no request and leaves the status set.
- R3: When message-capable (bit 15) and message-enable (bit 14) are both set, a match drives that channel's message request for one cycle. The address is message-register bits 63:32 and the data is bits 31:0. No pin request is made and the pin route is ignored.
- R4: With message delivery off, route field bits 13:9 choose the pin. A route of 0 means the channel is unconnected, and a match then raises nothing.
- R5: With the type bit (bit 1) clear, a match makes a one-cycle pulse request on the routed pin and does not touch the status bit.
- R6: With the type bit set, a match sets the channel's status bit and makes a one-cycle assert request on the routed pin.
- R7: Config layout. Writable bits are 1 (type), 2 (enable), 3 (periodic select), 6 (value-set), 13:9 (route) and 14 (message enable). Bits 63:32 hold the read-only allowed-route mask. Bit 15 (message-capable) and bit 4 (periodic-capable) are read-only ones. Bit 5 (size) and bit 8 (32-bit mode) read as zero, and so do all other bits. Reset value is the mask in the upper half with 0x8010 in the lower half. Writes use a per-bit mask.
- R8: After a config write, a nonzero route whose bit is clear in the allowed-route mask is forced to 0.
- R9: A config write that changes the word while status is set clears the status bit and sends a deassert request on the old pin. This happens if the result has enable clear, message delivery on, edge type, or a different pin.
- R10: A status-clear strobe on a channel whose status is set clears it and sends a deassert request on its pin. On a channel whose status is clear it has no effect.
- R11: A config write that leaves the word unchanged has no side effects: no request, and the status bit is kept.
- R12: The allowed-route mask is 0xFF000000 for 32 or more controller pins, 0xF shifted left by (PIN_COUNT-4) for 20 to 31 pins, and 0 below 20. The default of 24 pins gives 0x00F00000.
- R13: A configuration write or status clear in the same cycle as a match takes effect before the match is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_i | input | NUM_CH | Per-channel comparator match strobe |
| wr_sel_i | input | SEL_W | Channel addressed by writes and by the config read port |
| cfg_we_i | input | 1 | Config word write strobe |
| msg_we_i | input | 1 | Message register write strobe |
| wdata_i | input | 64 | Write data |
| wmask_i | input | 64 | Per-bit write mask |
| sts_clr_i | input | NUM_CH | Per-channel status clear strobe |
| cfg_rdata_o | output | 64 | Config word of the selected channel |
| status_o | output | NUM_CH | Level-status bits |
| pin_assert_o | output | 32 | Per-pin level assert request |
| pin_deassert_o | output | 32 | Per-pin level deassert request |
| pin_pulse_o | output | 32 | Per-pin edge pulse request |
| msg_req_o | output | NUM_CH | Per-channel message request |
| msg_addr_o | output | NUM_CH*32 | Message address, channel c at bits c*32 +: 32 |
| msg_data_o | output | NUM_CH*32 | Message data, channel c at bits c*32 +: 32 |

## Verification
Suppose a status bit is wrongly set or cleared. The next match on that channel then gives the wrong answer one cycle later: either it is silently dropped or it is asserted a second time. A later config change or status clear also shows it, because the deassert it sends, or fails to send, is visible on the pin vectors. A corrupted config word shows up at once on the read port. If instead the route or delivery mode is wrong inside the logic, the next match request lands on the wrong pin or on the message port. The reference model compares every output on every cycle, so such a fault is caught in the first cycle it reaches a port.

// File: rtl/tir_pkg.sv
package tir_pkg;

    localparam int RT_W  = 5;
    localparam int PIN_N = 1 << RT_W;

    // Config word bit positions
    localparam int B_LEVEL = 1;
    localparam int B_IE    = 2;
    localparam int B_PSEL  = 3;
    localparam int B_PCAP  = 4;
    localparam int B_SIZE  = 5;
    localparam int B_VSET  = 6;
    localparam int B_W32   = 8;
    localparam int B_RT    = 9;
    localparam int B_MEN   = 14;
    localparam int B_MCAP  = 15;

    localparam logic [63:0] WR_MASK =
        (64'd1 << B_LEVEL) | (64'd1 << B_IE) | (64'd1 << B_PSEL) |
        (64'd1 << B_VSET) | (64'(PIN_N - 1) << B_RT) | (64'd1 << B_MEN);

    typedef struct packed {
        logic [63:0] cfg;
        logic [63:0] msg;
        logic        sts;
    } chan_state_t;

    typedef struct packed {
        logic            as_v;
        logic [RT_W-1:0] as_pin;
        logic            de_v;
        logic [RT_W-1:0] de_pin;
        logic            pu_v;
        logic [RT_W-1:0] pu_pin;
        logic            msg_v;
        logic [31:0]     addr;
        logic [31:0]     data;
    } chan_evt_t;

    function automatic logic [31:0] allowed_routes(input int pins);
        if (pins >= 32)      return 32'hFF00_0000;
        else if (pins >= 20) return 32'hF << (pins - 4);
        else                 return 32'h0;
    endfunction

    function automatic logic msg_mode(input logic [63:0] c);
        return c[B_MCAP] & c[B_MEN];
    endfunction

    function automatic logic [RT_W-1:0] pin_of(input logic [63:0] c);
        return msg_mode(c) ? '0 : c[B_RT +: RT_W];
    endfunction

endpackage

// File: rtl/tir_cfg_update.sv
module tir_cfg_update
    import tir_pkg::*;
#(
    parameter logic [31:0] ALLOW = 32'h0
) (
    input  logic [63:0] old_i,
    input  logic [63:0] wdata_i,
    input  logic [63:0] wmask_i,
    output logic [63:0] new_o,
    output logic        changed_o
);
    logic [63:0]     eff_mask;
    logic [63:0]     merged;
    logic [RT_W-1:0] route;

    always_comb begin
        eff_mask = wmask_i & WR_MASK;
        merged   = (old_i & ~eff_mask) | (wdata_i & eff_mask);
        route    = merged[B_RT +: RT_W];
        new_o    = merged;
        // a route outside the allowed set falls back to unconnected
        if (route != '0 && !ALLOW[route]) begin
            new_o[B_RT +: RT_W] = '0;
        end
        changed_o = (new_o != old_i);
    end

endmodule

// File: rtl/tir_chan.sv
module tir_chan
    import tir_pkg::*;
#(
    parameter logic [31:0] ALLOW   = 32'h0,
    parameter bit          MSG_CAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        match_i,
    input  logic        cfg_we_i,
    input  logic        msg_we_i,
    input  logic [63:0] wdata_i,
    input  logic [63:0] wmask_i,
    input  logic        sts_clr_i,
    output logic [63:0] cfg_o,
    output logic        sts_o,
    output chan_evt_t   evt_o
);
    localparam logic [63:0] RST_CFG = {ALLOW, 32'h0} |
        (64'(MSG_CAP) << B_MCAP) | (64'd1 << B_PCAP);

    chan_state_t state_d, state_q;
    chan_evt_t   evt_d, evt_q;

    logic [63:0] cfg_new;
    logic        cfg_changed;

    tir_cfg_update #(.ALLOW(ALLOW)) u_upd (
        .old_i     (state_q.cfg),
        .wdata_i   (wdata_i),
        .wmask_i   (wmask_i),
        .new_o     (cfg_new),
        .changed_o (cfg_changed)
    );

    always_comb begin
        logic [RT_W-1:0] old_pin;
        logic [RT_W-1:0] cur_pin;
        chan_state_t     s;
        chan_evt_t       ev;

        s       = state_q;
        ev      = '0;
        old_pin = pin_of(state_q.cfg);

        // 1. configuration write with stuck-level release
        if (cfg_we_i && cfg_changed) begin
            s.cfg = cfg_new;
            if (s.sts && (!cfg_new[B_IE] || msg_mode(cfg_new) ||
                          !cfg_new[B_LEVEL] || pin_of(cfg_new) != old_pin)) begin
                s.sts     = 1'b0;
                ev.de_v   = 1'b1;
                ev.de_pin = old_pin;
            end
        end

        // 2. message register write
        if (msg_we_i) begin
            s.msg = (s.msg & ~wmask_i) | (wdata_i & wmask_i);
        end

        // 3. software status clear
        cur_pin = pin_of(s.cfg);
        if (sts_clr_i && s.sts) begin
            s.sts     = 1'b0;
            ev.de_v   = 1'b1;
            ev.de_pin = cur_pin;
        end

        // 4. match delivery
        if (match_i && s.cfg[B_IE] && !s.sts) begin
            if (msg_mode(s.cfg)) begin
                ev.msg_v = 1'b1;
                ev.addr  = s.msg[63:32];
                ev.data  = s.msg[31:0];
            end else if (cur_pin != '0) begin
                if (s.cfg[B_LEVEL]) begin
                    s.sts     = 1'b1;
                    ev.as_v   = 1'b1;
                    ev.as_pin = cur_pin;
                end else begin
                    ev.pu_v   = 1'b1;
                    ev.pu_pin = cur_pin;
                end
            end
        end

        state_d = s;
        evt_d   = ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{cfg: RST_CFG, msg: 64'h0, sts: 1'b0};
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            evt_q   <= evt_d;
        end
    end

    assign cfg_o = state_q.cfg;
    assign sts_o = state_q.sts;
    assign evt_o = evt_q;

    // R1: disabled channel stays silent
    assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !cfg_we_i && !state_q.cfg[B_IE]) |=>
        !(evt_q.as_v || evt_q.pu_v || evt_q.msg_v));

    // R2: pending level swallows further matches
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && state_q.sts && !cfg_we_i && !sts_clr_i) |=>
        (!evt_q.as_v && !evt_q.pu_v && !evt_q.msg_v && state_q.sts));

    // R3: message requests never coexist with pin raises
    assert_msg_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.msg_v |-> (!evt_q.as_v && !evt_q.pu_v && msg_mode(state_q.cfg)));

    // R6: status rising goes with an assert on the routed pin
    assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.sts) |-> (evt_q.as_v && evt_q.as_pin == pin_of(state_q.cfg)));

    // R7: read-only fields keep their values
    assert_ro_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cfg[63:32] == ALLOW && !state_q.cfg[B_W32] && !state_q.cfg[B_SIZE] &&
         state_q.cfg[B_PCAP] && state_q.cfg[B_MCAP] == MSG_CAP));

    // R8: stored route is always legal
    assert_route_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cfg[B_RT +: RT_W] != '0) |-> ALLOW[state_q.cfg[B_RT +: RT_W]]);

    // R9, R10: status falling always releases the pin
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.sts) |-> evt_q.de_v);

endmodule

// File: rtl/tir_pin_merge.sv
module tir_pin_merge
    import tir_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  chan_evt_t            evt_i [NUM_CH],
    output logic [PIN_N-1:0]     pin_assert_o,
    output logic [PIN_N-1:0]     pin_deassert_o,
    output logic [PIN_N-1:0]     pin_pulse_o,
    output logic [NUM_CH-1:0]    msg_req_o,
    output logic [NUM_CH*32-1:0] msg_addr_o,
    output logic [NUM_CH*32-1:0] msg_data_o
);
    always_comb begin
        pin_assert_o   = '0;
        pin_deassert_o = '0;
        pin_pulse_o    = '0;
        msg_req_o      = '0;
        msg_addr_o     = '0;
        msg_data_o     = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (evt_i[c].as_v) pin_assert_o[evt_i[c].as_pin]   = 1'b1;
            if (evt_i[c].de_v) pin_deassert_o[evt_i[c].de_pin] = 1'b1;
            if (evt_i[c].pu_v) pin_pulse_o[evt_i[c].pu_pin]    = 1'b1;
            msg_req_o[c] = evt_i[c].msg_v;
            if (evt_i[c].msg_v) begin
                msg_addr_o[c*32 +: 32] = evt_i[c].addr;
                msg_data_o[c*32 +: 32] = evt_i[c].data;
            end
        end
    end

endmodule

// File: rtl/tir_router.sv
module tir_router
    import tir_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int PIN_COUNT = 24,
    parameter bit MSG_CAP   = 1'b1,
    localparam int SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    match_i,
    input  logic [SEL_W-1:0]     wr_sel_i,
    input  logic                 cfg_we_i,
    input  logic                 msg_we_i,
    input  logic [63:0]          wdata_i,
    input  logic [63:0]          wmask_i,
    input  logic [NUM_CH-1:0]    sts_clr_i,
    output logic [63:0]          cfg_rdata_o,
    output logic [NUM_CH-1:0]    status_o,
    output logic [31:0]          pin_assert_o,
    output logic [31:0]          pin_deassert_o,
    output logic [31:0]          pin_pulse_o,
    output logic [NUM_CH-1:0]    msg_req_o,
    output logic [NUM_CH*32-1:0] msg_addr_o,
    output logic [NUM_CH*32-1:0] msg_data_o
);
    localparam logic [31:0] ALLOW = allowed_routes(PIN_COUNT);

    chan_evt_t   evt   [NUM_CH];
    logic [63:0] cfg_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = (wr_sel_i == SEL_W'(g));
        tir_chan #(.ALLOW(ALLOW), .MSG_CAP(MSG_CAP)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .match_i   (match_i[g]),
            .cfg_we_i  (cfg_we_i && hit),
            .msg_we_i  (msg_we_i && hit),
            .wdata_i   (wdata_i),
            .wmask_i   (wmask_i),
            .sts_clr_i (sts_clr_i[g]),
            .cfg_o     (cfg_q[g]),
            .sts_o     (status_o[g]),
            .evt_o     (evt[g])
        );
    end

    tir_pin_merge #(.NUM_CH(NUM_CH)) u_merge (
        .evt_i          (evt),
        .pin_assert_o   (pin_assert_o),
        .pin_deassert_o (pin_deassert_o),
        .pin_pulse_o    (pin_pulse_o),
        .msg_req_o      (msg_req_o),
        .msg_addr_o     (msg_addr_o),
        .msg_data_o     (msg_data_o)
    );

    assign cfg_rdata_o = cfg_q[wr_sel_i];

    // R4: pin 0 means unconnected and never receives a raise
    assert_pin0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_assert_o[0] && !pin_pulse_o[0]));

    // R12: only allowed pins are ever raised
    assert_allowed_pins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_assert_o | pin_pulse_o) & ~ALLOW) == 32'h0);

endmodule

// File: tb/tir_router_test.sv
module tir_router_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  NCH        = 4;
    localparam logic [31:0] ALLOW_EXP = 32'h00F0_0000;  // R12 at 24 pins

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    match_i = '0;
    logic [1:0]        wr_sel_i = '0;
    logic              cfg_we_i = 1'b0;
    logic              msg_we_i = 1'b0;
    logic [63:0]       wdata_i = '0;
    logic [63:0]       wmask_i = '0;
    logic [NCH-1:0]    sts_clr_i = '0;
    logic [63:0]       cfg_rdata_o;
    logic [NCH-1:0]    status_o;
    logic [31:0]       pin_assert_o, pin_deassert_o, pin_pulse_o;
    logic [NCH-1:0]    msg_req_o;
    logic [NCH*32-1:0] msg_addr_o, msg_data_o;

    tir_router #(.NUM_CH(NCH), .PIN_COUNT(24), .MSG_CAP(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .match_i(match_i), .wr_sel_i(wr_sel_i),
        .cfg_we_i(cfg_we_i), .msg_we_i(msg_we_i), .wdata_i(wdata_i),
        .wmask_i(wmask_i), .sts_clr_i(sts_clr_i), .cfg_rdata_o(cfg_rdata_o),
        .status_o(status_o), .pin_assert_o(pin_assert_o),
        .pin_deassert_o(pin_deassert_o), .pin_pulse_o(pin_pulse_o),
        .msg_req_o(msg_req_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R7";

    // reference model state
    logic [63:0]       m_cfg [NCH];
    logic [63:0]       m_msg [NCH];
    logic [NCH-1:0]    m_sts;
    logic [31:0]       e_as, e_de, e_pu;
    logic [NCH-1:0]    e_mreq;
    logic [NCH*32-1:0] e_addr, e_data;

    function automatic int route_of(input logic [63:0] c);
        if (c[15] && c[14]) return 0;
        return int'(c[13:9]);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_cfg[c] = {ALLOW_EXP, 32'h0000_8010};
            m_msg[c] = '0;
        end
        m_sts = '0; e_as = '0; e_de = '0; e_pu = '0;
        e_mreq = '0; e_addr = '0; e_data = '0;
    endtask

    task automatic model_step();
        e_as = '0; e_de = '0; e_pu = '0; e_mreq = '0; e_addr = '0; e_data = '0;
        for (int c = 0; c < NCH; c++) begin
            logic [63:0] nc;
            logic [63:0] mk;
            int op;
            int rt;
            op = route_of(m_cfg[c]);
            if (cfg_we_i && int'(wr_sel_i) == c) begin
                mk = wmask_i & 64'h7E4E;
                nc = (m_cfg[c] & ~mk) | (wdata_i & mk);
                rt = int'(nc[13:9]);
                if (rt != 0 && !ALLOW_EXP[rt]) nc[13:9] = 5'd0;
                if (nc != m_cfg[c]) begin
                    m_cfg[c] = nc;
                    if (m_sts[c] && (!nc[2] || (nc[15] && nc[14]) || !nc[1] ||
                                     route_of(nc) != op)) begin
                        m_sts[c] = 1'b0;
                        e_de[op] = 1'b1;
                    end
                end
            end
            if (msg_we_i && int'(wr_sel_i) == c)
                m_msg[c] = (m_msg[c] & ~wmask_i) | (wdata_i & wmask_i);
            if (sts_clr_i[c] && m_sts[c]) begin
                m_sts[c] = 1'b0;
                e_de[route_of(m_cfg[c])] = 1'b1;
            end
            if (match_i[c] && m_cfg[c][2] && !m_sts[c]) begin
                if (m_cfg[c][15] && m_cfg[c][14]) begin
                    e_mreq[c] = 1'b1;
                    e_addr[c*32 +: 32] = m_msg[c][63:32];
                    e_data[c*32 +: 32] = m_msg[c][31:0];
                end else if (route_of(m_cfg[c]) != 0) begin
                    if (m_cfg[c][1]) begin
                        m_sts[c] = 1'b1;
                        e_as[route_of(m_cfg[c])] = 1'b1;
                    end else begin
                        e_pu[route_of(m_cfg[c])] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic compare();
        vectors++;
        if (status_o !== m_sts || pin_assert_o !== e_as || pin_deassert_o !== e_de ||
            pin_pulse_o !== e_pu || msg_req_o !== e_mreq || msg_addr_o !== e_addr ||
            msg_data_o !== e_data || cfg_rdata_o !== m_cfg[wr_sel_i]) begin
            miscompares++;
            $display("FAIL %s: sts %h/%h as %h/%h de %h/%h pu %h/%h mq %h/%h addr %h/%h data %h/%h cfg %h/%h (act/exp)",
                cur_req, status_o, m_sts, pin_assert_o, e_as, pin_deassert_o, e_de,
                pin_pulse_o, e_pu, msg_req_o, e_mreq, msg_addr_o, e_addr,
                msg_data_o, e_data, cfg_rdata_o, m_cfg[wr_sel_i]);
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    // one clock: model, edge, compare, return inputs to idle
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        match_i = '0; cfg_we_i = 1'b0; msg_we_i = 1'b0; sts_clr_i = '0;
        wdata_i = '0; wmask_i = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wcfg(input int ch, input logic [63:0] d, input logic [63:0] m);
        wr_sel_i = 2'(ch); cfg_we_i = 1'b1; wdata_i = d; wmask_i = m; cyc();
    endtask

    task automatic wmsg(input int ch, input logic [63:0] d, input logic [63:0] m);
        wr_sel_i = 2'(ch); msg_we_i = 1'b1; wdata_i = d; wmask_i = m; cyc();
    endtask

    task automatic fire(input logic [NCH-1:0] b);
        match_i = b; cyc();
    endtask

    task automatic clr(input logic [NCH-1:0] b);
        sts_clr_i = b; cyc();
    endtask

    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R7"; compare();
        check("R7", cfg_rdata_o, 64'h00F0_0000_0000_8010);
        check("R12", {32'h0, cfg_rdata_o[63:32]}, 64'h0000_0000_00F0_0000);

        // R7 and R8: all-ones write; route 31 is illegal
        cur_req = "R7"; wcfg(0, ALL, ALL);
        check("R8", cfg_rdata_o, 64'h00F0_0000_0000_C05E);
        wcfg(0, 64'h0, ALL);
        check("R7", cfg_rdata_o, 64'h00F0_0000_0000_8010);

        // R12: pin 23 legal, 19 illegal
        cur_req = "R12"; wcfg(2, 64'h2E00, ALL);
        check("R12", {59'h0, cfg_rdata_o[13:9]}, 64'd23);
        cur_req = "R8"; wcfg(2, 64'h2600, ALL);
        check("R8", {59'h0, cfg_rdata_o[13:9]}, 64'd0);
        fire(4'b0100);

        // R1: enable clear
        cur_req = "R1"; wcfg(1, 64'h2802, ALL); fire(4'b0010); idle(1);

        // R6: level on pin 20
        cur_req = "R6"; wcfg(1, 64'h2806, ALL); fire(4'b0010);
        check("R6", {60'h0, status_o}, 64'h2);

        // R2: already pending
        cur_req = "R2"; fire(4'b0010); fire(4'b0010);

        // R10: status clear, then clear on idle channel
        cur_req = "R10"; clr(4'b0010); clr(4'b0010); clr(4'b1111);

        // R5: edge on pin 21
        cur_req = "R5"; wcfg(2, 64'h2A04, ALL); fire(4'b0100); fire(4'b0100); idle(1);

        // R4: route zero
        cur_req = "R4"; wcfg(3, 64'h0006, ALL); fire(4'b1000);

        // R3: message delivery overrides route
        cur_req = "R3";
        wmsg(3, 64'h1234_5678_9ABC_DEF0, ALL);
        wcfg(3, 64'h6C06, ALL); fire(4'b1000);
        wmsg(3, 64'hCAFE_F00D_0000_0000, 64'hFFFF_FFFF_0000_0000); fire(4'b1000);
        check("R3", {32'h0, msg_addr_o[127:96]}, 64'h0000_0000_CAFE_F00D);
        fire(4'b1110);

        // R9: stuck level released on route change, disable, edge, message
        cur_req = "R9";
        fire(4'b0010); wcfg(1, 64'h2A06, ALL);
        fire(4'b0010); wcfg(1, 64'h2A02, ALL);
        wcfg(1, 64'h2A06, ALL); fire(4'b0010); wcfg(1, 64'h2A04, ALL);
        wcfg(1, 64'h2A06, ALL); fire(4'b0010); wcfg(1, 64'h6A06, ALL);
        wcfg(1, 64'h2806, ALL); fire(4'b0010);
        // changed but still level on same pin: status kept
        wcfg(1, 64'h2846, ALL);

        // R11: unchanged word and read-only-only write
        cur_req = "R11"; wcfg(1, 64'h2846, ALL);
        wcfg(1, 64'hFFFF_FFFF_0000_8130, 64'hFFFF_FFFF_0000_8130);
        wcfg(1, 64'h2800, 64'h0000_0000_0000_3E00);
        check("R11", {63'h0, status_o[1]}, 64'h1);

        // R13: same-cycle ordering
        cur_req = "R13";
        sts_clr_i = 4'b0010; match_i = 4'b0010; cyc();
        wr_sel_i = 2'd0; cfg_we_i = 1'b1; wdata_i = 64'h2C06; wmask_i = ALL;
        match_i = 4'b0001; cyc();
        wr_sel_i = 2'd0; cfg_we_i = 1'b1; wdata_i = 64'h2E06; wmask_i = ALL;
        match_i = 4'b0001; cyc();
        fire(4'b1111); clr(4'b1111); fire(4'b1111); idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: act timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule